// File: doc/BRIEF.md
# Nibble-to-Byte Dual-Clock FIFO

This block moves 4-bit nibbles from one clock domain to 8-bit bytes in another. The writer pushes one nibble per accepted cycle on its own clock. The reader pops one byte per accepted cycle on a second, unrelated clock. Each byte is built from two nibbles that were written one after the other. The read side only ever counts whole bytes. A nibble that is still waiting for its partner never makes the FIFO look non-empty, and it never shows up in the read-side word count.

The write pointer counts nibbles and the read pointer counts bytes. Each pointer is turned into Gray code and passed into the other domain through a chain of synchronizer flops. A single asynchronous clear input resets both sides. Each side releases its own reset in step with its own clock, so the empty output never shows a transient that a register on the read side could capture.

Top module: `nibByteFifo`

## Requirements
- R1: Within a byte, the nibble written first sits in rdByte[3:0] and the nibble written second sits in rdByte[7:4].
- R2: A single unpaired nibble leaves empty at 1 and rdWords at 0, however long it waits.
- R3: Once the second nibble of a pair reaches the read domain, empty falls to 0. If that byte is then read while only an odd nibble remains, empty returns to 1.
- R4: rdWords is the number of complete bytes held, from 0 to 16. empty is 1 exactly when rdWords is 0.
- R5: rdByte is registered. It changes only on the rdClk edge that accepts a read (rdReq high while empty is 0), and it holds its value on every other edge.
- R6: full is 1 while 32 nibbles are held. A write while full is dropped and does not disturb stored data. full falls again after a byte has been read.
- R7: A read request while empty is dropped: rdByte and rdWords do not change.
- R8: While clrAsync is high, empty is 1, full is 0, rdWords is 0 and rdByte is 0. After a clear, any leftover odd nibble is gone.
- R9: Bytes leave in the order in which their nibbles were written, across the whole 16-byte depth and across pointer wrap.
- R10: A pointer update reaches the other domain after a synchronizer chain of SYNC_STAGES flops (4 by default) in that domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| clrAsync | input | 1 | Asynchronous clear, active high |
| wrReq | input | 1 | Write request for wrNib |
| wrNib | input | 4 | Nibble to store |
| full | output | 1 | Storage holds 32 nibbles (write domain) |
| rdReq | input | 1 | Read request for one byte |
| rdByte | output | 8 | Registered byte from the last accepted read |
| empty | output | 1 | No complete byte available (read domain) |
| rdWords | output | 5 | Count of complete bytes held (read domain) |

## Verification
Some internal faults show up only at the ports, through the flags and the count:
- A wrong nibble-to-byte comparison would let a lone nibble clear empty, or count it in rdWords. This is visible within a few read cycles after the odd write.
- A wrong full threshold or a missing overflow guard would corrupt the first byte read after a write to a full FIFO.
- A broken Gray conversion or a broken synchronizer chain would leave the flags stuck or wrong after a pointer update, once the settle window has passed.

Nibble order and FIFO order are checked byte by byte across a complete fill and drain.

// File: rtl/nbfPkg.sv
package nbfPkg;
  localparam int NIB_W       = 4;
  localparam int BYTE_W      = 2 * NIB_W;
  localparam int BYTE_AW     = 4;
  localparam int DEPTH_BYTES = 1 << BYTE_AW;
  localparam int NIB_AW      = BYTE_AW + 1;
  localparam int WPTR_W      = NIB_AW + 1;
  localparam int RPTR_W      = BYTE_AW + 1;

  typedef struct packed {
    logic              wrEn;
    logic [NIB_AW-1:0] wrAddr;
    logic              rdEn;
    logic [BYTE_AW-1:0] rdAddr;
  } nbfStrobe_t;
endpackage

// File: rtl/nbfSync.sv
module nbfSync #(
  parameter int W      = 4,
  parameter int STAGES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nbfRstSync.sv
module nbfRstSync (
  input  logic clk,
  input  logic clrAsync,
  output logic rstOut
);
  logic [1:0] hold;

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) hold <= 2'b11;
    else          hold <= {hold[0], 1'b0};
  end

  assign rstOut = hold[1];
endmodule

// File: rtl/nbfCtrl.sv
module nbfCtrl
  import nbfPkg::*;
#(
  parameter int SYNC_STAGES = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstW,
  input  logic              rstR,
  input  logic              wrReq,
  input  logic              rdReq,
  output logic              full,
  output logic              empty,
  output logic [RPTR_W-1:0] rdWords,
  output logic [WPTR_W-1:0] wFill,
  output nbfStrobe_t        strb
);
  localparam logic [WPTR_W-1:0] CAP_NIBS = WPTR_W'(2 * DEPTH_BYTES);

  // write domain: nibble pointer
  logic [WPTR_W-1:0] wBin, wGray, wNext;
  logic [RPTR_W-1:0] rGraySyncW, rBinW;
  logic              wrAcc;

  assign wNext = wBin + 1'b1;
  assign wrAcc = wrReq && !full;

  always_ff @(posedge wrClk or posedge rstW) begin
    if (rstW) begin
      wBin  <= '0;
      wGray <= '0;
    end else if (wrAcc) begin
      wBin  <= wNext;
      wGray <= wNext ^ (wNext >> 1);
    end
  end

  // read domain: byte pointer
  logic [RPTR_W-1:0] rBin, rGray, rNext;
  logic [WPTR_W-1:0] wGraySyncR, wBinR, nibDiff;
  logic              rdAcc;

  assign rNext = rBin + 1'b1;
  assign rdAcc = rdReq && !empty;

  always_ff @(posedge rdClk or posedge rstR) begin
    if (rstR) begin
      rBin  <= '0;
      rGray <= '0;
    end else if (rdAcc) begin
      rBin  <= rNext;
      rGray <= rNext ^ (rNext >> 1);
    end
  end

  // pointer crossings
  nbfSync #(.W(RPTR_W), .STAGES(SYNC_STAGES)) u_syncR2W (
    .clk(wrClk), .rst(rstW), .d(rGray), .q(rGraySyncW)
  );
  nbfSync #(.W(WPTR_W), .STAGES(SYNC_STAGES)) u_syncW2R (
    .clk(rdClk), .rst(rstR), .d(wGray), .q(wGraySyncR)
  );

  always_comb begin
    rBinW[RPTR_W-1] = rGraySyncW[RPTR_W-1];
    for (int i = RPTR_W - 2; i >= 0; i--) rBinW[i] = rBinW[i+1] ^ rGraySyncW[i];
    wBinR[WPTR_W-1] = wGraySyncR[WPTR_W-1];
    for (int i = WPTR_W - 2; i >= 0; i--) wBinR[i] = wBinR[i+1] ^ wGraySyncR[i];
  end

  // flags: write side in nibbles, read side in whole bytes
  assign wFill   = wBin - {rBinW, 1'b0};
  assign full    = (wFill == CAP_NIBS);
  assign nibDiff = wBinR - {rBin, 1'b0};
  assign empty   = (nibDiff < WPTR_W'(2));
  assign rdWords = nibDiff[WPTR_W-1:1];

  assign strb.wrEn   = wrAcc;
  assign strb.wrAddr = wBin[NIB_AW-1:0];
  assign strb.rdEn   = rdAcc;
  assign strb.rdAddr = rBin[BYTE_AW-1:0];
endmodule

// File: rtl/nbfData.sv
module nbfData
  import nbfPkg::*;
(
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstR,
  input  nbfStrobe_t        strb,
  input  logic [NIB_W-1:0]  wrNib,
  output logic [BYTE_W-1:0] rdByte
);
  logic [NIB_W-1:0] mem [2*DEPTH_BYTES];

  always_ff @(posedge wrClk) begin
    if (strb.wrEn) mem[strb.wrAddr] <= wrNib;
  end

  always_ff @(posedge rdClk or posedge rstR) begin
    if (rstR)
      rdByte <= '0;
    else if (strb.rdEn)
      rdByte <= {mem[{strb.rdAddr, 1'b1}], mem[{strb.rdAddr, 1'b0}]};
  end
endmodule

// File: rtl/nibByteFifo.sv
module nibByteFifo #(
  parameter int SYNC_STAGES = 4
) (
  input  logic                      wrClk,
  input  logic                      rdClk,
  input  logic                      clrAsync,
  input  logic                      wrReq,
  input  logic [nbfPkg::NIB_W-1:0]  wrNib,
  output logic                      full,
  input  logic                      rdReq,
  output logic [nbfPkg::BYTE_W-1:0] rdByte,
  output logic                      empty,
  output logic [nbfPkg::RPTR_W-1:0] rdWords
);
  logic                      rstW, rstR;
  logic [nbfPkg::WPTR_W-1:0] wFill;
  nbfPkg::nbfStrobe_t        strb;

  nbfRstSync u_rstW (.clk(wrClk), .clrAsync(clrAsync), .rstOut(rstW));
  nbfRstSync u_rstR (.clk(rdClk), .clrAsync(clrAsync), .rstOut(rstR));

  nbfCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstW(rstW), .rstR(rstR),
    .wrReq(wrReq), .rdReq(rdReq), .full(full), .empty(empty),
    .rdWords(rdWords), .wFill(wFill), .strb(strb)
  );

  nbfData u_data (
    .wrClk(wrClk), .rdClk(rdClk), .rstR(rstR), .strb(strb),
    .wrNib(wrNib), .rdByte(rdByte)
  );
endmodule

// File: rtl/nibByteFifoChk.sv
module nibByteFifoChk (
  input logic       wrClk,
  input logic       rdClk,
  input logic       clrAsync,
  input logic       rdReq,
  input logic       full,
  input logic       empty,
  input logic [4:0] rdWords,
  input logic [7:0] rdByte,
  input logic [5:0] wFill
);
  p_words_bound_r4: assert property (@(posedge rdClk) disable iff (clrAsync)
    rdWords <= 5'd16);

  p_empty_words_r4: assert property (@(posedge rdClk) disable iff (clrAsync)
    empty == (rdWords == 5'd0));

  p_hold_data_r5: assert property (@(posedge rdClk) disable iff (clrAsync)
    !rdReq |=> $stable(rdByte));

  p_no_underflow_r7: assert property (@(posedge rdClk) disable iff (clrAsync)
    (rdReq && empty) |=> $stable(rdByte));

  p_no_overflow_r6: assert property (@(posedge wrClk) disable iff (clrAsync)
    wFill <= 6'd32);

  p_clear_read_r8: assert property (@(posedge rdClk)
    clrAsync |-> (empty && rdWords == 5'd0 && rdByte == 8'd0));

  p_clear_write_r8: assert property (@(posedge wrClk)
    clrAsync |-> !full);
endmodule

bind nibByteFifo nibByteFifoChk u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .clrAsync(clrAsync), .rdReq(rdReq),
  .full(full), .empty(empty), .rdWords(rdWords), .rdByte(rdByte),
  .wFill(wFill)
);

// File: tb/sim_nibByteFifo.sv
module sim_nibByteFifo;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int WATCHDOG   = 2_000_000;
  localparam int NVEC       = 9;

  // {isRead, nibble, expected byte, expected word count}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 4'ha, 8'h00, 5'd0},
    {1'b0, 4'h5, 8'h00, 5'd1},
    {1'b0, 4'h3, 8'h00, 5'd1},
    {1'b1, 4'h0, 8'h5a, 5'd0},
    {1'b0, 4'hc, 8'h00, 5'd1},
    {1'b0, 4'he, 8'h00, 5'd1},
    {1'b0, 4'h7, 8'h00, 5'd2},
    {1'b1, 4'h0, 8'hc3, 5'd1},
    {1'b1, 4'h0, 8'h7e, 5'd0}
  };

  logic wrClk = 0, rdClk = 0, clrAsync = 0, wrReq = 0, rdReq = 0;
  logic [3:0] wrNib = '0;
  logic       full, empty;
  logic [7:0] rdByte;
  logic [4:0] rdWords;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2)  rdClk = ~rdClk;

  nibByteFifo u0 (
    .wrClk(wrClk), .rdClk(rdClk), .clrAsync(clrAsync), .wrReq(wrReq),
    .wrNib(wrNib), .full(full), .rdReq(rdReq), .rdByte(rdByte),
    .empty(empty), .rdWords(rdWords)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pushNib(input logic [3:0] n);
    @(negedge wrClk); wrReq = 1; wrNib = n;
    @(negedge wrClk); wrReq = 0;
  endtask

  task automatic popByte();
    @(negedge rdClk); rdReq = 1;
    @(negedge rdClk); rdReq = 0;
  endtask

  task automatic settle();
    repeat (10) @(negedge rdClk);
    repeat (10) @(negedge wrClk);
  endtask

  task automatic doClear();
    @(negedge rdClk); clrAsync = 1;
    repeat (3) @(negedge rdClk);
    chk("R8 empty", 32'(empty), 32'd1);
    chk("R8 full", 32'(full), 32'd0);
    chk("R8 words", 32'(rdWords), 32'd0);
    chk("R8 byte", 32'(rdByte), 32'd0);
    clrAsync = 0;
    settle();
  endtask

  initial begin
    #(WATCHDOG);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    clrAsync = 1;
    repeat (4) @(negedge rdClk);
    chk("R8 reset empty", 32'(empty), 32'd1);
    chk("R8 reset full", 32'(full), 32'd0);
    chk("R8 reset words", 32'(rdWords), 32'd0);
    clrAsync = 0;
    settle();

    // R1 R2 R3 R4: vector walk
    for (int i = 0; i < NVEC; i++) begin
      logic [17:0] v;
      v = VEC[i];
      if (v[17]) begin
        popByte();
        chk("R1/R5 byte", 32'(rdByte), 32'(v[12:5]));
      end else begin
        pushNib(v[16:13]);
      end
      settle();
      chk("R4 words", 32'(rdWords), 32'(v[4:0]));
      chk("R2/R3 empty", 32'(empty), 32'(v[4:0] == 5'd0));
    end

    // R7: read while empty is ignored
    popByte();
    settle();
    chk("R7 byte held", 32'(rdByte), 32'h7e);
    chk("R7 words", 32'(rdWords), 32'd0);

    // R8: clear drops a stored byte and a leftover odd nibble
    pushNib(4'h1); pushNib(4'h2); pushNib(4'h3);
    settle();
    chk("R3 words before clear", 32'(rdWords), 32'd1);
    doClear();
    pushNib(4'h4);
    settle();
    chk("R8 odd nibble dropped", 32'(rdWords), 32'd0);
    pushNib(4'h5);
    settle();
    chk("R8 words after clear", 32'(rdWords), 32'd1);
    popByte();
    chk("R8/R1 byte after clear", 32'(rdByte), 32'h54);
    settle();
    chk("R3 empty after drain", 32'(empty), 32'd1);

    // R6 R9: fill, overflow attempt, drain (pointers not at zero: wrap)
    for (int k = 0; k < 32; k++) pushNib(4'(k));
    settle();
    chk("R6 full", 32'(full), 32'd1);
    chk("R4 words at capacity", 32'(rdWords), 32'd16);
    pushNib(4'h9);
    settle();
    chk("R6 words unchanged", 32'(rdWords), 32'd16);
    chk("R6 still full", 32'(full), 32'd1);
    popByte();
    chk("R6 first byte intact", 32'(rdByte), 32'h10);
    settle();
    chk("R6 full released", 32'(full), 32'd0);
    chk("R10 words after read", 32'(rdWords), 32'd15);
    for (int k = 1; k < 16; k++) begin
      popByte();
      chk("R9 order", 32'(rdByte), 32'({4'(2*k+1), 4'(2*k)}));
    end
    settle();
    chk("R4 empty after drain", 32'(empty), 32'd1);
    chk("R4 words after drain", 32'(rdWords), 32'd0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule